// File: doc/BRIEF.md
# Calibrated Code-to-Millivolt Converter

This block turns a raw 12-bit converter code into a voltage in millivolts. The conversion runs along a straight line through two points of known voltage. The code coordinates of those two points are trimmed per device by two 16-bit calibration words, one for a high-range line and one for a low-range line. Supervisory logic loads those words once at start-up and may load them again later.

A result taken from the low-range line is then corrected for the resistor divider in front of the input for that channel. The divider depends on the channel number and on a scale selector. The corrected value is rounded to the nearest millivolt. Two channels skip this step: one reads the high-range line directly and one reads the low-range line directly.

The block accepts one request at a time on a valid/ready input. It presents the result on a valid/ready output, together with an error flag. The flag marks a calibration that has collapsed the line to a single code.

Top module: `adcv_conv_top`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. The line points are uncalibrated: high range code 3310 at 4200 mV and code 2832 at 3600 mV; low range code 3413 at 1000 mV and code 341 at 100 mV.
- R2: A cal_load pulse replaces each line's code points with (byte + nominal - 128) * 4. In each word, bits 7:0 trim point 0 and bits 15:8 trim point 1. The nominal codes are 856 and 733 for the high range and 833 and 80 for the low range. Conversions accepted on any later cycle use the new points.
- R3: The line voltage is (v0 - v1) * (code - c1) / (c0 - c1) + v1, in signed arithmetic. The division truncates toward zero.
- R4: A line voltage below zero becomes 0.
- R5: Channel 5 returns the high-range line voltage and channel 1 returns the low-range line voltage, both unchanged, for every scale value.
- R6: Any other channel takes the low-range line voltage V and returns (V * den + num / 2) / num, using integer division. This rounds to nearest, with halves rounding up.
- R7: The ratios num/den for scales 0, 1, 2 and 3 are as follows. Channel 14: 68/900, 68/1760, 68/2327, 68/3654. Channel 16: 48/100, 480/1955, 480/2586, 48/406. Channels 21, 22 and 23: 3/8, 375/1955, 375/2586, 300/3248. Any other channel: 1/1, 1000/1955, 1000/2586, 100/406.
- R8: Scale values 4 to 7 use the ratio 1/1 on every channel.
- R9: When the two code points of the selected line are equal, the result is 0 with out_err set to 1. Otherwise out_err is 0.
- R10: The input is accepted on a cycle with in_valid and in_ready both high. in_ready then stays low until the result has been taken with out_valid and out_ready both high. While out_ready is low, out_valid, out_mv and out_err hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_load | input | 1 | Load both calibration words this cycle |
| cal_big_word | input | 16 | High-range trim bytes (7:0 point 0, 15:8 point 1) |
| cal_small_word | input | 16 | Low-range trim bytes (7:0 point 0, 15:8 point 1) |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_code | input | 12 | Raw converter code |
| in_chan | input | 5 | Channel number |
| in_scale | input | 3 | Scale selector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_mv | output | 32 | Result in millivolts |
| out_err | output | 1 | Degenerate line: result forced to 0 |

## Verification
The hardest cases to reach are the ones where the trim bytes reshape the line. The high-range trim can make c0 - c1 zero or negative, and the low-range trim can drive the line voltage below zero. None of these happen with the power-on points. The bench therefore loads chosen calibration words before some of its sweeps. The high-range word 0x7B00 makes the two points equal. The word 0xFF00 gives a negative denominator on the high range and a clamped result at low codes on the low range. Every channel group, all eight scale values and codes at both ends of the range are then run against each of these calibrations.

// File: rtl/adcv_pkg.sv
// Shared constants and types for the calibrated code-to-millivolt converter.
// Assumes codes fit in 12 bits and ratios fit in 16-bit fields.
package adcv_pkg;
    localparam int CODE_W  = 12;
    localparam int CHAN_W  = 5;
    localparam int SCALE_W = 3;
    localparam int CAL_W   = 16;
    localparam int PT_W    = 16;
    localparam int MV_W    = 32;
    localparam int DIV_W   = 40;

    // line voltages (mV)
    localparam int HI_V0 = 4200;
    localparam int HI_V1 = 3600;
    localparam int LO_V0 = 1000;
    localparam int LO_V1 = 100;
    // nominal code points trimmed by calibration
    localparam int HI_NOM0 = 856;
    localparam int HI_NOM1 = 733;
    localparam int LO_NOM0 = 833;
    localparam int LO_NOM1 = 80;
    // uncalibrated power-on code points
    localparam int HI_RST0 = 3310;
    localparam int HI_RST1 = 2832;
    localparam int LO_RST0 = 3413;
    localparam int LO_RST1 = 341;
    localparam int TRIM_BIAS = 128;
    localparam int TRIM_GAIN = 4;

    localparam int CH_HI_DIRECT = 5;
    localparam int CH_LO_DIRECT = 1;

    typedef logic signed [PT_W-1:0] pt_t;
    typedef struct packed { pt_t c0; pt_t c1; } line_pts_t;

    // divider ratio: numerator in the upper half, denominator in the lower
    typedef struct packed { logic [15:0] num; logic [15:0] den; } ratio_t;

    typedef enum logic [1:0] {ST_IDLE, ST_DIV1, ST_DIV2, ST_DONE} conv_state_t;

    function automatic ratio_t mk_ratio(int n, int d);
        ratio_t r;
        r.num = n[15:0];
        r.den = d[15:0];
        return r;
    endfunction
endpackage

// File: rtl/adcv_calib_regs.sv
// Holds the trimmed code points of both lines.
// Assumes cal_load is a single-cycle strobe; points change only on it.
module adcv_calib_regs
    import adcv_pkg::*;
#(
    parameter int CAL_W = adcv_pkg::CAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_load,
    input  logic [CAL_W-1:0] big_word,
    input  logic [CAL_W-1:0] small_word,
    output line_pts_t        hi_pts,
    output line_pts_t        lo_pts
);
    localparam int BYTE_W = CAL_W / 2;

    function automatic pt_t trim(logic [BYTE_W-1:0] b, int nominal);
        int t;
        t = (int'(b) + nominal - TRIM_BIAS) * TRIM_GAIN;
        return pt_t'(t);
    endfunction

    // recompute and hold the points on each calibration load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_pts.c0 <= pt_t'(HI_RST0);
            hi_pts.c1 <= pt_t'(HI_RST1);
            lo_pts.c0 <= pt_t'(LO_RST0);
            lo_pts.c1 <= pt_t'(LO_RST1);
        end else if (cal_load) begin
            hi_pts.c0 <= trim(big_word[BYTE_W-1:0], HI_NOM0);
            hi_pts.c1 <= trim(big_word[CAL_W-1:BYTE_W], HI_NOM1);
            lo_pts.c0 <= trim(small_word[BYTE_W-1:0], LO_NOM0);
            lo_pts.c1 <= trim(small_word[CAL_W-1:BYTE_W], LO_NOM1);
        end
    end

    assert_cal_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cal_load) |-> ($stable(hi_pts) && $stable(lo_pts)));
endmodule

// File: rtl/adcv_ratio_lut.sv
// Maps channel and scale to the input divider ratio.
// Scales beyond the table fall back to unity.
module adcv_ratio_lut
    import adcv_pkg::*;
#(
    parameter int CHAN_W  = adcv_pkg::CHAN_W,
    parameter int SCALE_W = adcv_pkg::SCALE_W
) (
    input  logic [CHAN_W-1:0]  chan,
    input  logic [SCALE_W-1:0] scale,
    output ratio_t             ratio
);
    // table lookup by channel group, then scale
    always_comb begin
        ratio = mk_ratio(1, 1);
        if (chan == CHAN_W'(14)) begin
            case (scale)
                SCALE_W'(0): ratio = mk_ratio(68, 900);
                SCALE_W'(1): ratio = mk_ratio(68, 1760);
                SCALE_W'(2): ratio = mk_ratio(68, 2327);
                SCALE_W'(3): ratio = mk_ratio(68, 3654);
                default:     ratio = mk_ratio(1, 1);
            endcase
        end else if (chan == CHAN_W'(16)) begin
            case (scale)
                SCALE_W'(0): ratio = mk_ratio(48, 100);
                SCALE_W'(1): ratio = mk_ratio(480, 1955);
                SCALE_W'(2): ratio = mk_ratio(480, 2586);
                SCALE_W'(3): ratio = mk_ratio(48, 406);
                default:     ratio = mk_ratio(1, 1);
            endcase
        end else if (chan >= CHAN_W'(21) && chan <= CHAN_W'(23)) begin
            case (scale)
                SCALE_W'(0): ratio = mk_ratio(3, 8);
                SCALE_W'(1): ratio = mk_ratio(375, 1955);
                SCALE_W'(2): ratio = mk_ratio(375, 2586);
                SCALE_W'(3): ratio = mk_ratio(300, 3248);
                default:     ratio = mk_ratio(1, 1);
            endcase
        end else begin
            case (scale)
                SCALE_W'(0): ratio = mk_ratio(1, 1);
                SCALE_W'(1): ratio = mk_ratio(1000, 1955);
                SCALE_W'(2): ratio = mk_ratio(1000, 2586);
                SCALE_W'(3): ratio = mk_ratio(100, 406);
                default:     ratio = mk_ratio(1, 1);
            endcase
        end
    end
endmodule

// File: rtl/adcv_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes start arrives only while idle and divisor is non-zero.
module adcv_divider #(
    parameter int W = adcv_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem;
    logic [W-1:0]     dsr;
    logic [CNT_W-1:0] cnt;
    logic [W:0]       shifted;
    logic [W:0]       diff;
    logic             qbit;

    // one trial subtraction per step
    always_comb begin
        shifted = {rem, quotient[W-1]};
        diff    = shifted - {1'b0, dsr};
        qbit    = ~diff[W];
    end

    // iterate W steps, then pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cnt      <= '0;
            rem      <= '0;
            dsr      <= '0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy     <= 1'b1;
                rem      <= '0;
                dsr      <= divisor;
                quotient <= dividend;
                cnt      <= CNT_W'(W);
            end else if (busy) begin
                rem      <= qbit ? diff[W-1:0] : shifted[W-1:0];
                quotient <= {quotient[W-2:0], qbit};
                cnt      <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_div_rem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < dsr));
endmodule

// File: rtl/adcv_conv_top.sv
// Calibrated code-to-millivolt converter: line interpolation, clamp,
// divider-ratio correction with rounding. One request in flight.
// Assumes calibration words come from outside; one shared divider.
module adcv_conv_top
    import adcv_pkg::*;
#(
    parameter int CODE_W  = adcv_pkg::CODE_W,
    parameter int CHAN_W  = adcv_pkg::CHAN_W,
    parameter int SCALE_W = adcv_pkg::SCALE_W,
    parameter int CAL_W   = adcv_pkg::CAL_W,
    parameter int MV_W    = adcv_pkg::MV_W,
    parameter int DIV_W   = adcv_pkg::DIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cal_load,
    input  logic [CAL_W-1:0]   cal_big_word,
    input  logic [CAL_W-1:0]   cal_small_word,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CODE_W-1:0]  in_code,
    input  logic [CHAN_W-1:0]  in_chan,
    input  logic [SCALE_W-1:0] in_scale,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [MV_W-1:0]    out_mv,
    output logic               out_err
);
    line_pts_t hi_pts, lo_pts, sel_pts;
    conv_state_t state;
    ratio_t rt;

    logic [CHAN_W-1:0]  chan_q;
    logic [SCALE_W-1:0] scale_q;
    logic               bypass_q, neg_q, go_q, err_q;
    logic signed [31:0] v1_q;
    logic [DIV_W-1:0]   div_a, div_b, quo;
    logic               div_busy, div_done;
    logic [MV_W-1:0]    mv_q;

    logic               use_hi;
    logic signed [31:0] code_s, c0_s, c1_s, v0_s, v1_s, num1, den1;
    logic signed [DIV_W-1:0] q_s, volt_s;
    logic [DIV_W-1:0]   clamp_v;

    adcv_calib_regs #(.CAL_W(CAL_W)) calib_i (
        .clk(clk), .rst_n(rst_n), .cal_load(cal_load),
        .big_word(cal_big_word), .small_word(cal_small_word),
        .hi_pts(hi_pts), .lo_pts(lo_pts)
    );

    adcv_ratio_lut #(.CHAN_W(CHAN_W), .SCALE_W(SCALE_W)) lut_i (
        .chan(chan_q), .scale(scale_q), .ratio(rt)
    );

    adcv_divider #(.W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .start(go_q),
        .dividend(div_a), .divisor(div_b),
        .busy(div_busy), .done(div_done), .quotient(quo)
    );

    function automatic logic [DIV_W-1:0] mag(logic signed [31:0] x);
        return DIV_W'(x < 0 ? -x : x);
    endfunction

    // select line and form the interpolation numerator and denominator
    always_comb begin
        use_hi  = (in_chan == CHAN_W'(CH_HI_DIRECT));
        sel_pts = use_hi ? hi_pts : lo_pts;
        code_s  = signed'(32'(in_code));
        c0_s    = 32'(signed'(sel_pts.c0));
        c1_s    = 32'(signed'(sel_pts.c1));
        v0_s    = use_hi ? 32'(HI_V0) : 32'(LO_V0);
        v1_s    = use_hi ? 32'(HI_V1) : 32'(LO_V1);
        num1    = (v0_s - v1_s) * (code_s - c1_s);
        den1    = c0_s - c1_s;
    end

    // apply quotient sign, add the base voltage, clamp negatives
    always_comb begin
        q_s     = neg_q ? -signed'(quo) : signed'(quo);
        volt_s  = q_s + DIV_W'(v1_q);
        clamp_v = volt_s[DIV_W-1] ? '0 : unsigned'(volt_s);
    end

    // sequencing: accept, interpolate, optionally ratio-correct, present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            chan_q   <= '0;
            scale_q  <= '0;
            bypass_q <= 1'b0;
            neg_q    <= 1'b0;
            go_q     <= 1'b0;
            err_q    <= 1'b0;
            v1_q     <= '0;
            div_a    <= '0;
            div_b    <= '0;
            mv_q     <= '0;
        end else begin
            go_q <= 1'b0;
            case (state)
                ST_IDLE: if (in_valid) begin
                    chan_q   <= in_chan;
                    scale_q  <= in_scale;
                    bypass_q <= use_hi || (in_chan == CHAN_W'(CH_LO_DIRECT));
                    v1_q     <= v1_s;
                    if (den1 == 0) begin
                        mv_q  <= '0;
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        err_q <= 1'b0;
                        neg_q <= (num1 < 0) ^ (den1 < 0);
                        div_a <= mag(num1);
                        div_b <= mag(den1);
                        go_q  <= 1'b1;
                        state <= ST_DIV1;
                    end
                end
                ST_DIV1: if (div_done) begin
                    if (bypass_q) begin
                        mv_q  <= MV_W'(clamp_v);
                        state <= ST_DONE;
                    end else begin
                        div_a <= clamp_v * DIV_W'(rt.den) + DIV_W'(rt.num >> 1);
                        div_b <= DIV_W'(rt.num);
                        go_q  <= 1'b1;
                        state <= ST_DIV2;
                    end
                end
                ST_DIV2: if (div_done) begin
                    mv_q  <= quo[MV_W-1:0];
                    state <= ST_DONE;
                end
                ST_DONE: if (out_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_DONE);
    assign out_mv    = mv_q;
    assign out_err   = err_q;

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mv) && $stable(out_err)));
    assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_mv == '0));
    assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> !div_busy);
endmodule

// File: tb/adcv_conv_top_tb.sv
module adcv_conv_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_load = 1'b0;
    logic [15:0] cal_big_word = '0;
    logic [15:0] cal_small_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_code = '0;
    logic [4:0]  in_chan = '0;
    logic [2:0]  in_scale = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_mv;
    logic        out_err;

    int total = 0;
    int bad = 0;
    longint hp0 = 3310, hp1 = 2832, lp0 = 3413, lp1 = 341;

    localparam int CHANS[10] = '{0, 1, 5, 14, 16, 21, 22, 23, 7, 31};

    always #4 clk = ~clk;

    adcv_conv_top dut_i (
        .clk(clk), .rst_n(rst_n), .cal_load(cal_load),
        .cal_big_word(cal_big_word), .cal_small_word(cal_small_word),
        .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
        .in_chan(in_chan), .in_scale(in_scale), .out_valid(out_valid),
        .out_ready(out_ready), .out_mv(out_mv), .out_err(out_err)
    );

    task automatic check(bit ok, string tag, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic void ratio_of(int ch, int sc, output longint n, output longint d);
        n = 1; d = 1;
        if (sc > 3) return;
        if (ch == 14) begin
            n = 68;
            d = (sc == 0) ? 900 : (sc == 1) ? 1760 : (sc == 2) ? 2327 : 3654;
        end else if (ch == 16) begin
            n = (sc == 0 || sc == 3) ? 48 : 480;
            d = (sc == 0) ? 100 : (sc == 1) ? 1955 : (sc == 2) ? 2586 : 406;
        end else if (ch >= 21 && ch <= 23) begin
            n = (sc == 0) ? 3 : (sc == 3) ? 300 : 375;
            d = (sc == 0) ? 8 : (sc == 1) ? 1955 : (sc == 2) ? 2586 : 3248;
        end else begin
            n = (sc == 0) ? 1 : (sc == 3) ? 100 : 1000;
            d = (sc == 0) ? 1 : (sc == 1) ? 1955 : (sc == 2) ? 2586 : 406;
        end
    endfunction

    function automatic longint model(int code, int ch, int sc, output bit e, output bit clamped);
        longint c0, c1, v0, v1, den, v, n, d;
        e = 1'b0; clamped = 1'b0;
        if (ch == 5) begin c0 = hp0; c1 = hp1; v0 = 4200; v1 = 3600; end
        else begin c0 = lp0; c1 = lp1; v0 = 1000; v1 = 100; end
        den = c0 - c1;
        if (den == 0) begin e = 1'b1; return 0; end
        v = ((v0 - v1) * (code - c1)) / den + v1;
        if (v < 0) begin v = 0; clamped = 1'b1; end
        if (ch == 1 || ch == 5) return v;
        ratio_of(ch, sc, n, d);
        return (v * d + n / 2) / n;
    endfunction

    task automatic load_cal(logic [15:0] bw, logic [15:0] sw);
        @(negedge clk);
        cal_big_word = bw; cal_small_word = sw; cal_load = 1'b1;
        hp0 = (longint'(bw[7:0]) + 856 - 128) * 4;
        hp1 = (longint'(bw[15:8]) + 733 - 128) * 4;
        lp0 = (longint'(sw[7:0]) + 833 - 128) * 4;
        lp1 = (longint'(sw[15:8]) + 80 - 128) * 4;
        @(negedge clk);
        cal_load = 1'b0;
    endtask

    task automatic convert(int code, int ch, int sc, int hold, string tag_in);
        bit e, cl;
        longint expv;
        string tag;
        int n;
        logic [31:0] snap;
        expv = model(code, ch, sc, e, cl);
        if (tag_in != "") tag = tag_in;
        else if (e) tag = "R9";
        else if (cl) tag = "R4";
        else if (ch == 1 || ch == 5) tag = "R5";
        else if (sc > 3) tag = "R8";
        else tag = "R7";
        n = 0;
        while (!in_ready && n < 500) begin @(negedge clk); n++; end
        in_code = 12'(code); in_chan = 5'(ch); in_scale = 3'(sc); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R10 busy after accept", longint'(in_ready), 0);
        n = 0;
        while (!out_valid && n < 2000) begin @(negedge clk); n++; end
        check(out_valid == 1'b1, "R10 result timeout", longint'(out_valid), 1);
        if (hold > 0) begin
            snap = out_mv;
            repeat (hold) @(negedge clk);
            check(out_valid == 1'b1 && out_mv == snap, "R10 hold while stalled",
                  longint'(out_mv), longint'(snap));
        end
        check(longint'(out_mv) == expv, tag, longint'(out_mv), expv);
        check(out_err == e, "R9 error flag", longint'(out_err), longint'(e));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10 release after take",
              longint'(out_valid), 0);
    endtask

    task automatic sweep();
        for (int ci = 0; ci < 10; ci++) begin
            for (int sc = 0; sc < 8; sc++) begin
                convert(0, CHANS[ci], sc, 0, "");
                convert(1500 + CHANS[ci] * 61 + sc * 7, CHANS[ci], sc, (sc == 2) ? 3 : 0, "");
                convert(4095, CHANS[ci], sc, 0, "");
            end
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
        // uncalibrated points land exactly on the line voltages
        convert(3310, 5, 0, 0, "R1 high point 0");
        convert(2832, 5, 1, 0, "R1 high point 1");
        convert(341, 1, 0, 0, "R1 low point 1");
        convert(3413, 1, 6, 0, "R1 low point 0");
        convert(3000, 5, 0, 0, "R3 truncating interpolation");
        convert(2000, 0, 1, 0, "R6 rounded ratio");
        convert(2777, 14, 3, 2, "R6 rounded ratio ch14");
        convert(2500, 14, 5, 0, "R8 scale beyond table");
        sweep();
        // trimmed points: bytes 0x05 (point 0) and 0x0A (point 1)
        load_cal(16'h0A05, 16'h1030);
        convert(2932, 5, 0, 0, "R2 high trimmed point 0");
        convert(2460, 5, 0, 0, "R2 high trimmed point 1");
        convert(2000, 22, 0, 0, "R2 low trimmed ratio path");
        // negative high denominator and low-range clamp
        load_cal(16'hFF00, 16'hFF00);
        convert(0, 1, 0, 0, "R4 clamp to zero");
        convert(4095, 5, 0, 0, "R3 negative denominator");
        sweep();
        // collapsed high line
        load_cal(16'h7B00, 16'h8080);
        convert(1234, 5, 0, 3, "R9 equal points");
        sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule